// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

A last-in first-out store of 64 eight-bit words held in flip-flops and addressed by a six-bit stack pointer that wraps around. A push request writes the input word onto the top of the stack. A pop request returns the top word on a registered output one cycle later. Every accepted operation updates the pointer and the two status flags in a single clock.

The pointer starts at zero. A push increments the pointer first and then writes at the new address, so the first word lands at address 1. The 64th word lands at address 0 once the pointer has wrapped. A pop reads at the current pointer and then decrements it. The flags are not derived from an occupancy count. The full flag is set when a push brings the pointer back to zero, and the empty flag is set when a pop brings it back to zero.

Three requests are refused: a push while full, a pop while empty, and a push and pop in the same cycle. A refused request raises a one-cycle error pulse and leaves the contents, the pointer and the flags untouched.

Top module: `stk_reg_stack`

## Requirements
- R1: After reset, sp_o = 0, empty_o = 1, full_o = 0, err_o = 0 and pop_valid_o = 0.
- R2: An accepted push (push_i = 1, pop_i = 0, full_o = 0) sets sp_o to its old value plus one, modulo 64, on the next clock. It stores push_data_i at that new address, so the first push after reset gives sp_o = 1.
- R3: An accepted pop (pop_i = 1, push_i = 0, empty_o = 0) drives the word at the current sp_o onto pop_data_o with pop_valid_o = 1 on the next clock. It also lowers sp_o by one, modulo 64. pop_valid_o is 0 in every other cycle.
- R4: Words are popped in the reverse of the order in which they were pushed, across the full depth of 64.
- R5: After an accepted push, empty_o = 0. full_o = 1 exactly when the new sp_o is 0, which is the 64th push from empty.
- R6: After an accepted pop, full_o = 0. empty_o = 1 exactly when the new sp_o is 0.
- R7: A push while full_o = 1 raises err_o for one cycle. It changes neither sp_o, the flags nor the stored words.
- R8: A pop while empty_o = 1 raises err_o for one cycle. It keeps pop_valid_o at 0 and changes neither sp_o nor the flags.
- R9: push_i and pop_i asserted together raise err_o for one cycle and change no state. err_o is 0 on the clock after any cycle with a single accepted request or no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | 8 | Word to push |
| pop_data_o | output | 8 | Popped word, registered |
| pop_valid_o | output | 1 | pop_data_o updated this cycle |
| sp_o | output | 6 | Stack pointer |
| full_o | output | 1 | Stack holds 64 words |
| empty_o | output | 1 | Stack holds no words |
| err_o | output | 1 | One-cycle pulse for a refused request |

## Verification
The properties assume that push_i and pop_i are sampled cleanly at the clock and that any combination of them may occur. This includes both together and requests against a full or empty stack, since those cases are part of the specified behaviour and not excluded. Because full and empty are only reachable through long one-sided runs, the stimulus alternates push-heavy and pop-heavy random phases. These random phases follow directed runs that fill the stack to 64 and drain it again. Inputs change only on the falling edge, so each request is held across exactly one rising edge.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_ERR  = 2'd3
  } stk_op_e;
endpackage

// File: rtl/stk_op_decode.sv
module stk_op_decode
  import stk_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    full_i,
  input  logic    empty_i,
  output stk_op_e op_o
);
  always_comb begin
    unique case ({push_i, pop_i})
      2'b10:   op_o = full_i  ? OP_ERR : OP_PUSH;
      2'b01:   op_o = empty_i ? OP_ERR : OP_POP;
      2'b11:   op_o = OP_ERR;
      default: op_o = OP_IDLE;
    endcase
  end
endmodule

// File: rtl/stk_ptr_ctrl.sv
module stk_ptr_ctrl
  import stk_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stk_op_e           op_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);
  logic [ADDR_W-1:0] sp_q, sp_inc, sp_dec;
  logic              full_q, empty_q, err_q;

  assign sp_inc = sp_q + ADDR_W'(1);
  assign sp_dec = sp_q - ADDR_W'(1);

  // write lands at the incremented pointer, read at the current one
  assign wr_en_o   = (op_i == OP_PUSH);
  assign wr_addr_o = sp_inc;
  assign rd_en_o   = (op_i == OP_POP);
  assign rd_addr_o = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      err_q <= (op_i == OP_ERR);
      unique case (op_i)
        OP_PUSH: begin
          sp_q    <= sp_inc;
          full_q  <= (sp_inc == '0);
          empty_q <= 1'b0;
        end
        OP_POP: begin
          sp_q    <= sp_dec;
          empty_q <= (sp_dec == '0);
          full_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign sp_o    = sp_q;
  assign full_o  = full_q;
  assign empty_o = empty_q;
  assign err_o   = err_q;
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [Depth];
  logic [Depth-1:0]  word_we;

  for (genvar g = 0; g < Depth; g++) begin : g_we
    assign word_we[g] = wr_en_i && (wr_addr_i == ADDR_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < Depth; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < Depth; i++) begin
        if (word_we[i]) mem_q[i] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
    end
  end
endmodule

// File: rtl/stk_reg_stack.sv
module stk_reg_stack
  import stk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_valid_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);
  stk_op_e           op;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  stk_op_decode u_dec (
    .push_i  (push_i),
    .pop_i   (pop_i),
    .full_i  (full_o),
    .empty_i (empty_o),
    .op_o    (op)
  );

  stk_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .sp_o      (sp_o),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .err_o     (err_o)
  );

  stk_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (push_data_i),
    .rd_en_i    (rd_en),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (pop_data_o),
    .rd_valid_o (pop_valid_o)
  );
endmodule

// File: rtl/stk_reg_stack_chk.sv
module stk_reg_stack_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic              pop_valid_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              err_o
);
  logic push_ok, pop_ok;
  assign push_ok = push_i && !pop_i && !full_o;
  assign pop_ok  = pop_i && !push_i && !empty_o;

  // R2
  push_sp_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ok |=> (sp_o == $past(sp_o) + ADDR_W'(1)) && !err_o);

  // R3
  pop_sp_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_ok |=> pop_valid_o && (sp_o == $past(sp_o) - ADDR_W'(1)));

  // R3
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_ok |=> !pop_valid_o);

  // R5
  push_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ok |=> !empty_o && (full_o == (sp_o == '0)));

  // R6
  pop_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_ok |=> !full_o && (empty_o == (sp_o == '0)));

  // R7
  push_full_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> err_o && full_o && (sp_o == $past(sp_o)));

  // R8
  pop_empty_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> err_o && empty_o && !pop_valid_o && (sp_o == $past(sp_o)));

  // R9
  both_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> err_o && !pop_valid_o && $stable(sp_o) && $stable(full_o) && $stable(empty_o));

  // R9
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ok || pop_ok || (!push_i && !pop_i)) |=> !err_o);

  // R5
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

bind stk_reg_stack stk_reg_stack_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .pop_valid_o (pop_valid_o),
  .sp_o        (sp_o),
  .full_o      (full_o),
  .empty_o     (empty_o),
  .err_o       (err_o)
);

// File: tb/tb_stk_reg_stack.sv
module tb_stk_reg_stack;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              push_i = 1'b0;
  logic              pop_i = 1'b0;
  logic [DATA_W-1:0] push_data_i = '0;
  logic [DATA_W-1:0] pop_data_o;
  logic              pop_valid_o;
  logic [ADDR_W-1:0] sp_o;
  logic              full_o, empty_o, err_o;

  int n_vec  = 0;
  int n_fail = 0;

  logic [DATA_W-1:0] model [DEPTH];
  logic [ADDR_W-1:0] m_sp = '0;
  logic              m_full = 1'b0;
  logic              m_empty = 1'b1;

  always #10 clk_i = ~clk_i;

  stk_reg_stack #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_data_i (push_data_i),
    .pop_data_o  (pop_data_o),
    .pop_valid_o (pop_valid_o),
    .sp_o        (sp_o),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .err_o       (err_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one request held across one rising edge, checked 1 ns after it
  task automatic step(input logic psh, input logic pp, input logic [DATA_W-1:0] d);
    string req;
    logic  e_err, e_valid;
    logic [DATA_W-1:0] e_data;
    e_err = 1'b0; e_valid = 1'b0; e_data = '0;
    @(negedge clk_i);
    push_i = psh; pop_i = pp; push_data_i = d;
    if (psh && pp) begin
      req = "R9"; e_err = 1'b1;
    end else if (psh && m_full) begin
      req = "R7"; e_err = 1'b1;
    end else if (pp && m_empty) begin
      req = "R8"; e_err = 1'b1;
    end else if (psh) begin
      req = "R2";
      m_sp = m_sp + ADDR_W'(1);
      model[m_sp] = d;
      m_full = (m_sp == '0);
      m_empty = 1'b0;
    end else if (pp) begin
      req = "R3";
      e_data = model[m_sp]; e_valid = 1'b1;
      m_sp = m_sp - ADDR_W'(1);
      m_empty = (m_sp == '0);
      m_full = 1'b0;
    end else begin
      req = "R9";
    end
    @(posedge clk_i); #1;
    check(req, "err", int'(err_o), int'(e_err));
    check(req, "pop_valid", int'(pop_valid_o), int'(e_valid));
    check(req, "sp", int'(sp_o), int'(m_sp));
    check(psh ? "R5" : "R6", "full", int'(full_o), int'(m_full));
    check(psh ? "R5" : "R6", "empty", int'(empty_o), int'(m_empty));
    if (e_valid) check("R4", "pop_data", int'(pop_data_o), int'(e_data));
    @(negedge clk_i);
    push_i = 1'b0; pop_i = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    #45 rst_ni = 1'b1;
    #2;
    // R1 reset state
    check("R1", "sp", int'(sp_o), 0);
    check("R1", "empty", int'(empty_o), 1);
    check("R1", "full", int'(full_o), 0);
    check("R1", "err", int'(err_o), 0);
    check("R1", "pop_valid", int'(pop_valid_o), 0);

    step(1'b0, 1'b1, 8'h00);          // R8 pop while empty
    step(1'b1, 1'b1, 8'h5A);          // R9 both on empty
    step(1'b1, 1'b0, 8'hC3);          // R2 first push
    check("R2", "first push address", int'(sp_o), 1);
    step(1'b0, 1'b1, 8'h00);          // R3/R6 back to empty
    check("R3", "pop of first word", int'(pop_data_o), 8'hC3);

    // R4/R5 fill to full depth, then refused requests
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, DATA_W'(i * 7 + 3));
    check("R5", "full after 64 pushes", int'(full_o), 1);
    check("R5", "sp wrapped to 0", int'(sp_o), 0);
    step(1'b1, 1'b0, 8'hEE);          // R7 push while full
    step(1'b1, 1'b1, 8'hEE);          // R9 both while full
    step(1'b0, 1'b0, 8'h00);          // idle, err drops
    // R4/R6/R7 drain: contents survived the refused push
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 8'h00);
    check("R6", "empty after drain", int'(empty_o), 1);

    for (int ph = 0; ph < 8; ph++) begin
      for (int k = 0; k < 400; k++) begin
        int r;
        logic ps, pp;
        r  = int'($urandom_range(0, 99));
        ps = (ph % 2 == 0) ? (r < 70) : (r < 25);
        pp = (ph % 2 == 0) ? (r >= 60) : (r >= 20);
        step(ps, pp, DATA_W'($urandom));
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule